// File: doc/BRIEF.md
# Chip Reset Sequencer

This block brings the chip out of reset. A power-on pulse restarts everything. The block then keeps the core and peripheral clocks gated off for a long oscillator settling window. After that it runs two short recovery phases. The core then fetches its reset vector: first the high byte at $FFFE, then the low byte at $FFFF. A watchdog timeout and an illegal-opcode flag from the core are the other two reset causes. Either of them skips the settling window and starts straight at the first recovery phase.

In every reset the block pulls the external reset pin low. This drive is open-drain style, and a high output means the pin is being pulled. The block also holds the core in reset until the second recovery phase ends. A small status register records the cause of the last reset. Power-on leaves only its own bit set. A watchdog or illegal-opcode reset leaves only the bits of the causes seen in that cycle. The register is read through a one-cycle registered read port.

Top module: `rst_seq`

## Requirements
- R1: While `por_i` is high, and right after it falls, `core_rst_o` and `rst_pin_drv_o` are 1, `clk_en_o` is 0, and the status value is 0x01 (bit 0 = power-on).
- R2: After `por_i` falls, `clk_en_o` stays 0 and the pin stays driven for exactly STAB_CYC (4096) clock cycles. `clk_en_o` becomes 1 after clock edge STAB_CYC.
- R3: The first recovery phase lasts REC_CYC (32) cycles, with clocks enabled, the pin driven and the core held in reset.
- R4: The second recovery phase lasts REC_CYC cycles, with the pin released and the core still in reset. `core_rst_o` falls on the edge that completes this phase.
- R5: In the cycle after `core_rst_o` falls, `vec_fetch_o` is 2'b01 (fetch at $FFFE). In the next cycle it is 2'b10 (fetch at $FFFF). After that it is 2'b00.
- R6: A `wdog_to_i` pulse while clocks are enabled makes the status 0x02 (bit 1). It also starts the first recovery phase on the next cycle, with no settling window.
- R7: An `illop_i` pulse while clocks are enabled makes the status 0x04 (bit 2) and starts the same recovery sequence.
- R8: Both sources in the same cycle give status 0x06. The power-on bit is always cleared by such a reset.
- R9: Requests during the settling window are ignored: the status stays 0x01 and the window length is unchanged.
- R10: `rd_data_o` shows the status one cycle after `rd_en_i` is high, and shows 0 one cycle after `rd_en_i` is low.
- R11: A request during a recovery or vector-fetch phase restarts the first recovery phase at full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| por_i | input | 1 | Power-on reset pulse, active high, asynchronous |
| wdog_to_i | input | 1 | Watchdog timeout pulse |
| illop_i | input | 1 | Illegal-opcode flag from the core |
| rd_en_i | input | 1 | Status read strobe |
| rd_data_o | output | STAT_W | Registered status read data |
| rst_pin_drv_o | output | 1 | 1 = pull the external reset pin low |
| core_rst_o | output | 1 | Internal reset to the core |
| clk_en_o | output | 1 | Enable for the core and peripheral clocks |
| vec_fetch_o | output | 2 | Vector fetch strobes: bit 0 for $FFFE, bit 1 for $FFFF |

## Verification
A directed power-on pass counts every phase boundary edge by edge. This tells an off-by-one in the settling or recovery counts apart from a wrong phase order. Seeded random rounds then choose watchdog only, illegal opcode only, or both at once, after a random idle time. The status readback separates the single-cause encodings from the merged one and shows that the power-on bit clears. Directed injections during the settling window and in the middle of a recovery phase show that the first is ignored and the second restarts the phase at full length.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
   typedef enum logic [2:0] {
      PH_STAB,
      PH_REC1,
      PH_REC2,
      PH_VEC_HI,
      PH_VEC_LO,
      PH_RUN
   } phase_e;
endpackage

// File: rtl/rst_seq_timer.sv
module rst_seq_timer #(
   parameter int CNT_W = 12
) (
   input  logic             clk_i,
   input  logic             por_i,
   input  logic             restart_i,
   input  logic [CNT_W-1:0] lim_i,
   output logic             done_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or posedge por_i) begin
      if (por_i)          cnt_q <= '0;
      else if (restart_i) cnt_q <= '0;
      else                cnt_q <= cnt_q + 1'b1;
   end

   assign done_o = (cnt_q == lim_i);
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
   import rst_seq_pkg::*;
#(
   parameter int CNT_W    = 12,
   parameter int STAB_CYC = 4096,
   parameter int REC_CYC  = 32
) (
   input  logic             clk_i,
   input  logic             por_i,
   input  logic             req_i,
   input  logic             done_i,
   output phase_e           ph_o,
   output logic             restart_o,
   output logic [CNT_W-1:0] lim_o
);
   localparam logic [CNT_W-1:0] STAB_LIM = CNT_W'(STAB_CYC - 1);
   localparam logic [CNT_W-1:0] REC_LIM  = CNT_W'(REC_CYC - 1);

   phase_e ph_q, ph_d;
   logic   step;

   always_comb begin
      ph_d = ph_q;
      step = 1'b0;
      unique case (ph_q)
         PH_STAB:   if (done_i) begin ph_d = PH_REC1; step = 1'b1; end
         PH_REC1:   if (done_i) begin ph_d = PH_REC2; step = 1'b1; end
         PH_REC2:   if (done_i) begin ph_d = PH_VEC_HI; step = 1'b1; end
         PH_VEC_HI: ph_d = PH_VEC_LO;
         PH_VEC_LO: ph_d = PH_RUN;
         default:   ph_d = PH_RUN;
      endcase
      if (req_i) ph_d = PH_REC1;
   end

   always_ff @(posedge clk_i or posedge por_i) begin
      if (por_i) ph_q <= PH_STAB;
      else       ph_q <= ph_d;
   end

   assign ph_o      = ph_q;
   assign restart_o = step | req_i;
   assign lim_o     = (ph_q == PH_STAB) ? STAB_LIM : REC_LIM;
endmodule

// File: rtl/rst_seq_status.sv
module rst_seq_status #(
   parameter int STAT_W   = 8,
   parameter int POR_BIT  = 0,
   parameter int WDOG_BIT = 1,
   parameter int ILOP_BIT = 2
) (
   input  logic              clk_i,
   input  logic              por_i,
   input  logic              req_i,
   input  logic              wdog_i,
   input  logic              ilop_i,
   input  logic              rd_en_i,
   output logic [STAT_W-1:0] stat_o,
   output logic [STAT_W-1:0] rd_data_o
);
   localparam logic [STAT_W-1:0] POR_MASK = STAT_W'(1) << POR_BIT;

   logic [STAT_W-1:0] stat_q, cause;

   always_comb begin
      cause = '0;
      cause[WDOG_BIT] = wdog_i;
      cause[ILOP_BIT] = ilop_i;
   end

   always_ff @(posedge clk_i or posedge por_i) begin
      if (por_i) begin
         stat_q    <= POR_MASK;
         rd_data_o <= '0;
      end else begin
         if (req_i) stat_q <= cause;
         rd_data_o <= rd_en_i ? stat_q : '0;
      end
   end

   assign stat_o = stat_q;
endmodule

// File: rtl/rst_seq.sv
module rst_seq
   import rst_seq_pkg::*;
#(
   parameter int STAB_CYC      = 4096,
   parameter int REC_CYC       = 32,
   parameter int STAT_W        = 8,
   parameter int POR_BIT       = 0,
   parameter int WDOG_BIT      = 1,
   parameter int ILOP_BIT      = 2,
   parameter bit PIN_HOLD_REC2 = 1'b0
) (
   input  logic              clk_i,
   input  logic              por_i,
   input  logic              wdog_to_i,
   input  logic              illop_i,
   input  logic              rd_en_i,
   output logic [STAT_W-1:0] rd_data_o,
   output logic              rst_pin_drv_o,
   output logic              core_rst_o,
   output logic              clk_en_o,
   output logic [1:0]        vec_fetch_o
);
   localparam int MAX_CYC = (STAB_CYC > REC_CYC) ? STAB_CYC : REC_CYC;
   localparam int CNT_W   = $clog2(MAX_CYC);

   if (STAB_CYC < 2 || REC_CYC < 2) begin : g_bad_len
      $error("rst_seq: phase lengths must be at least 2");
   end
   if (POR_BIT >= STAT_W || WDOG_BIT >= STAT_W || ILOP_BIT >= STAT_W) begin : g_bad_pos
      $error("rst_seq: status bit outside register");
   end
   if (POR_BIT == WDOG_BIT || POR_BIT == ILOP_BIT || WDOG_BIT == ILOP_BIT) begin : g_bad_dup
      $error("rst_seq: status bits must differ");
   end

   phase_e            ph;
   logic              req, restart, done;
   logic [CNT_W-1:0]  lim;
   logic [STAT_W-1:0] stat_q;

   assign req = (wdog_to_i | illop_i) & (ph != PH_STAB);

   rst_seq_fsm #(.CNT_W(CNT_W), .STAB_CYC(STAB_CYC), .REC_CYC(REC_CYC)) u_fsm (
      .clk_i(clk_i), .por_i(por_i), .req_i(req), .done_i(done),
      .ph_o(ph), .restart_o(restart), .lim_o(lim)
   );

   rst_seq_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk_i(clk_i), .por_i(por_i), .restart_i(restart), .lim_i(lim), .done_o(done)
   );

   rst_seq_status #(.STAT_W(STAT_W), .POR_BIT(POR_BIT), .WDOG_BIT(WDOG_BIT),
                    .ILOP_BIT(ILOP_BIT)) u_stat (
      .clk_i(clk_i), .por_i(por_i), .req_i(req), .wdog_i(wdog_to_i), .ilop_i(illop_i),
      .rd_en_i(rd_en_i), .stat_o(stat_q), .rd_data_o(rd_data_o)
   );

   if (PIN_HOLD_REC2) begin : g_pin_long
      assign rst_pin_drv_o = (ph == PH_STAB) | (ph == PH_REC1) | (ph == PH_REC2);
   end else begin : g_pin_short
      assign rst_pin_drv_o = (ph == PH_STAB) | (ph == PH_REC1);
   end

   assign core_rst_o  = (ph == PH_STAB) | (ph == PH_REC1) | (ph == PH_REC2);
   assign clk_en_o    = (ph != PH_STAB);
   assign vec_fetch_o = {ph == PH_VEC_LO, ph == PH_VEC_HI};
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk #(
   parameter int STAT_W   = 8,
   parameter int WDOG_BIT = 1,
   parameter int ILOP_BIT = 2
) (
   input logic              clk_i,
   input logic              por_i,
   input logic              wdog_to_i,
   input logic              illop_i,
   input logic              rd_en_i,
   input logic [STAT_W-1:0] rd_data_o,
   input logic              rst_pin_drv_o,
   input logic              core_rst_o,
   input logic              clk_en_o,
   input logic [1:0]        vec_fetch_o,
   input logic [STAT_W-1:0] stat_q
);
   logic [STAT_W-1:0] exp_cause;
   always_comb begin
      exp_cause = '0;
      exp_cause[WDOG_BIT] = wdog_to_i;
      exp_cause[ILOP_BIT] = illop_i;
   end

   a_r2_clk_off_pin: assert property (@(posedge clk_i) disable iff (por_i)
      !clk_en_o |-> (rst_pin_drv_o && core_rst_o));
   a_r4_pin_core: assert property (@(posedge clk_i) disable iff (por_i)
      rst_pin_drv_o |-> core_rst_o);
   a_r4_release_fetch: assert property (@(posedge clk_i) disable iff (por_i)
      $fell(core_rst_o) |-> (vec_fetch_o == 2'b01));
   a_r5_vec_onehot: assert property (@(posedge clk_i) disable iff (por_i)
      $onehot0(vec_fetch_o));
   a_r5_vec_order: assert property (@(posedge clk_i) disable iff (por_i)
      (vec_fetch_o == 2'b01 && !wdog_to_i && !illop_i) |=> (vec_fetch_o == 2'b10));
   a_r6_req_restart: assert property (@(posedge clk_i) disable iff (por_i)
      (clk_en_o && (wdog_to_i || illop_i)) |=> (rst_pin_drv_o && core_rst_o && clk_en_o));
   a_r8_cause_bits: assert property (@(posedge clk_i) disable iff (por_i)
      (clk_en_o && (wdog_to_i || illop_i)) |=> (stat_q == $past(exp_cause)));
   a_r9_stab_ignore: assert property (@(posedge clk_i) disable iff (por_i)
      !clk_en_o |=> $stable(stat_q));
   a_r10_rd_idle: assert property (@(posedge clk_i) disable iff (por_i)
      !rd_en_i |=> (rd_data_o == '0));
   a_r10_rd_value: assert property (@(posedge clk_i) disable iff (por_i)
      rd_en_i |=> (rd_data_o == $past(stat_q)));
endmodule

bind rst_seq rst_seq_chk #(.STAT_W(STAT_W), .WDOG_BIT(WDOG_BIT), .ILOP_BIT(ILOP_BIT)) u_chk (
   .clk_i(clk_i), .por_i(por_i), .wdog_to_i(wdog_to_i), .illop_i(illop_i),
   .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .rst_pin_drv_o(rst_pin_drv_o),
   .core_rst_o(core_rst_o), .clk_en_o(clk_en_o), .vec_fetch_o(vec_fetch_o),
   .stat_q(stat_q)
);

// File: tb/rst_seq_tb.sv
module rst_seq_tb;
   localparam int STAB = 4096;
   localparam int REC  = 32;

   logic       clk = 1'b0;
   logic       por = 1'b1, wdog = 1'b0, ilop = 1'b0, rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       pin, core_rst, clk_en;
   logic [1:0] vec;
   int         total = 0, bad = 0;

   always #10 clk = ~clk;

   rst_seq u_dut (
      .clk_i(clk), .por_i(por), .wdog_to_i(wdog), .illop_i(ilop), .rd_en_i(rd_en),
      .rd_data_o(rd_data), .rst_pin_drv_o(pin), .core_rst_o(core_rst),
      .clk_en_o(clk_en), .vec_fetch_o(vec)
   );

   function automatic logic [7:0] cause_val(input logic w, input logic i);
      return {5'b0, i, w, 1'b0};
   endfunction

   function automatic logic [4:0] pack_out(input logic p, c, e, input logic [1:0] v);
      return {p, c, e, v};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic read_stat(input string req, input logic [7:0] exp);
      rd_en = 1'b1; tick(1); rd_en = 1'b0;
      chk(req, 32'(rd_data), 32'(exp));
      tick(1);
      chk("R10 idle read", 32'(rd_data), 32'h0);
   endtask

   // entered just after the edge that starts the first recovery phase
   task automatic chk_from_rec1(input string tag);
      chk({"R3 rec1 start ", tag}, 32'(pack_out(pin, core_rst, clk_en, vec)), 32'b11100);
      tick(REC - 1);
      chk({"R3 rec1 end ", tag}, 32'(pack_out(pin, core_rst, clk_en, vec)), 32'b11100);
      tick(1);
      chk({"R4 rec2 start ", tag}, 32'(pack_out(pin, core_rst, clk_en, vec)), 32'b01100);
      tick(REC - 1);
      chk({"R4 rec2 end ", tag}, 32'(pack_out(pin, core_rst, clk_en, vec)), 32'b01100);
      tick(1);
      chk({"R5 fetch hi ", tag}, 32'(pack_out(pin, core_rst, clk_en, vec)), 32'b00101);
      tick(1);
      chk({"R5 fetch lo ", tag}, 32'(pack_out(pin, core_rst, clk_en, vec)), 32'b00110);
      tick(1);
      chk({"R5 run ", tag}, 32'(pack_out(pin, core_rst, clk_en, vec)), 32'b00100);
   endtask

   task automatic fire(input logic w, input logic i);
      wdog = w; ilop = i; tick(1); wdog = 1'b0; ilop = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      // R1 reset state during power-on
      tick(3);
      chk("R1 during por", 32'(pack_out(pin, core_rst, clk_en, vec)), 32'b11000);
      por = 1'b0;
      chk("R1 after por", 32'(pack_out(pin, core_rst, clk_en, vec)), 32'b11000);
      read_stat("R1 status", 8'h01);         // 2 edges used
      tick(STAB - 3);
      chk("R2 stab last", 32'(pack_out(pin, core_rst, clk_en, vec)), 32'b11000);
      tick(1);
      chk_from_rec1("por");

      // R9: second power-on, inject during settling
      por = 1'b1; tick(1); por = 1'b0;
      tick(100);
      fire(1'b1, 1'b1);                      // 101 edges
      read_stat("R9 status kept", 8'h01);    // 103 edges
      tick(STAB - 104);
      chk("R9 stab length", 32'(clk_en), 32'h0);
      tick(1);
      chk_from_rec1("por2");

      // R6 R7 R8 directed
      fire(1'b1, 1'b0); chk_from_rec1("R6 wdog"); read_stat("R6 status", 8'h02);
      fire(1'b0, 1'b1); chk_from_rec1("R7 ilop"); read_stat("R7 status", 8'h04);
      fire(1'b1, 1'b1); chk_from_rec1("R8 both"); read_stat("R8 status", 8'h06);

      // R11 restart mid-recovery
      fire(1'b1, 1'b0);
      tick(10);
      fire(1'b0, 1'b1);
      chk_from_rec1("R11 restart");
      read_stat("R11 status", 8'h04);

      // random rounds
      for (int k = 0; k < 8; k++) begin
         int idle = $urandom_range(0, 20);
         int sel  = $urandom_range(1, 3);
         logic w = sel[0], i = sel[1];
         tick(idle);
         fire(w, i);
         chk_from_rec1("R8 random");
         read_stat("R8 random status", cause_val(w, i));
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule